// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes stereo PCM from a three-wire serial audio link and turns it into parallel samples. The three wires are a bit clock, a word-select clock and a data line. All three are sampled in one system clock domain. They pass through synchronizers, and rising edges of the bit clock are found by edge detection. Each completed left/right pair is presented as two 24-bit words with a one-cycle valid pulse.

A 3-bit format code picks the framing. The left-justified and I2S-style modes are counted forward from the word-select edge. The three right-justified modes find the word at the end of each half-frame: a running shift register is read when word select toggles. Words shorter than 24 bits are sign-extended. A new format code is taken over only where a left half-frame begins, so a frame is never decoded with two framings.

Top module: `serial_audio_rx`

## Requirements
- R1: With format code 000, 001 or 100, the word is 16, 20 or 24 bits and is right-justified: its LSB sits in the last bit slot before word select toggles. Bit slots before the word are ignored.
- R2: With format code 010, the word is 24 bits and left-justified: its MSB sits in the bit slot where word select toggles. Bit slots after the 24th are ignored.
- R3: With format code 011 (I2S-style), the MSB sits one bit slot after the word-select toggle. With 24 slots per half, the LSB falls in the first slot of the following half.
- R4: Data is sampled at rising bit-clock edges, MSB first, two's complement. 16- and 20-bit words are sign-extended to 24 bits on `left_out`/`right_out`.
- R5: In codes 000, 001, 010 and 100 the left half is the one with word select high; in code 011 it is the one with word select low. `left_out` and `right_out` update together, with a one-cycle `valid_out`, once the right word is complete, and they hold their values at all other times.
- R6: A change of `fmt_in` takes effect only at the word-select toggle that starts a left half. A frame already under way finishes in the previous format.
- R7: Codes 101, 110 and 111 capture nothing, and `valid_out` stays low while they are active.
- R8: After reset, `left_out` and `right_out` are zero and `valid_out` is low.
- R9: Every format decodes correctly with half-frames from its minimum length (16, 20 or 24 slots) up to at least 32 slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Serial bit clock (asynchronous) |
| ws_in | input | 1 | Word-select clock (asynchronous) |
| sd_in | input | 1 | Serial data (asynchronous) |
| fmt_in | input | 3 | Framing code, see R1 to R3 and R7 |
| left_out | output | DW | Left sample, sign-extended |
| right_out | output | DW | Right sample, sign-extended |
| valid_out | output | 1 | One-cycle pulse when a new pair is presented |

## Verification
Every format is swept at its minimum half-frame length and at 32 slots per half. Each run sends zero, largest positive, most negative, all-ones and pseudo-random words. The extreme words show whether the bit order and sign extension are right. The data line idles at one in every unused slot, so a word window placed one slot off shows up as a wrong value. One stream switches from the left-justified code to the 24-bit right-justified code in the middle of a frame, to show that the change waits for a left-half boundary. One stream uses an unsupported code and must produce no valid pulse at all.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
  localparam logic [2:0] FMT_LSB16 = 3'b000;
  localparam logic [2:0] FMT_LSB20 = 3'b001;
  localparam logic [2:0] FMT_MSB24 = 3'b010;
  localparam logic [2:0] FMT_I2S24 = 3'b011;
  localparam logic [2:0] FMT_LSB24 = 3'b100;

  // Level of word select that marks the left half-frame
  function automatic logic left_level(input logic [2:0] f);
    return (f != FMT_I2S24);
  endfunction
endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sarx_framer.sv
module sarx_framer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_s,
  input  logic             ws_s,
  output logic             bit_stb,
  output logic             ws_chg,
  output logic             ws_last,
  output logic             locked,
  output logic [CNT_W-1:0] pos
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             sclk_d;
  logic             primed_q;
  logic             ws_q;
  logic             locked_q;
  logic [CNT_W-1:0] cnt_q;

  assign bit_stb = sclk_s & ~sclk_d;
  assign ws_chg  = bit_stb & primed_q & (ws_s ^ ws_q);
  assign ws_last = ws_q;
  assign locked  = locked_q;
  // Slot index of the current bit counted from the previous toggle (saturating)
  assign pos     = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d   <= 1'b0;
      primed_q <= 1'b0;
      ws_q     <= 1'b0;
      locked_q <= 1'b0;
      cnt_q    <= CNT_MAX;
    end else begin
      sclk_d <= sclk_s;
      if (bit_stb) begin
        primed_q <= 1'b1;
        ws_q     <= ws_s;
        if (ws_chg) begin
          cnt_q    <= '0;
          locked_q <= 1'b1;
        end else begin
          cnt_q <= pos;
        end
      end
    end
  end
endmodule

// File: rtl/sarx_capture.sv
module sarx_capture
  import sarx_pkg::*;
#(
  parameter int DW    = 24,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_stb,
  input  logic             bit_sd,
  input  logic             ws_chg,
  input  logic             locked,
  input  logic [CNT_W-1:0] pos,
  input  logic [2:0]       fmt,
  output logic             word_stb,
  output logic [DW-1:0]    word
);
  localparam logic [CNT_W-1:0] POS_MSB_END = CNT_W'(DW - 1);
  localparam logic [CNT_W-1:0] POS_I2S_END = CNT_W'(DW);

  logic [DW-1:0] sh_q;
  logic [DW-1:0] full;

  always_ff @(posedge clk) begin
    if (rst)          sh_q <= '0;
    else if (bit_stb) sh_q <= {sh_q[DW-2:0], bit_sd};
  end

  assign full = {sh_q[DW-2:0], bit_sd};

  always_comb begin
    word_stb = 1'b0;
    word     = '0;
    case (fmt)
      FMT_LSB16: begin
        word_stb = ws_chg & locked;
        word     = {{(DW-16){sh_q[15]}}, sh_q[15:0]};
      end
      FMT_LSB20: begin
        word_stb = ws_chg & locked;
        word     = {{(DW-20){sh_q[19]}}, sh_q[19:0]};
      end
      FMT_LSB24: begin
        word_stb = ws_chg & locked;
        word     = sh_q;
      end
      FMT_MSB24: begin
        word_stb = bit_stb & (pos == POS_MSB_END);
        word     = full;
      end
      FMT_I2S24: begin
        word_stb = bit_stb & (pos == POS_I2S_END);
        word     = full;
      end
      default: begin
        word_stb = 1'b0;
        word     = '0;
      end
    endcase
  end

  // R4
  word_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    word_stb |-> bit_stb);

  // R7
  no_capture_bad_fmt_chk: assert property (@(posedge clk) disable iff (rst)
    word_stb |-> (fmt <= FMT_LSB24));
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter int DW          = 24,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk_in,
  input  logic          ws_in,
  input  logic          sd_in,
  input  logic [2:0]    fmt_in,
  output logic [DW-1:0] left_out,
  output logic [DW-1:0] right_out,
  output logic          valid_out
);
  logic [2:0]       raw_v, syn_v;
  logic             sclk_s, ws_s, sd_s;
  logic             bit_stb, ws_chg, ws_last, locked;
  logic [CNT_W-1:0] pos;
  logic [2:0]       fmt_act;
  logic             word_stb, is_left;
  logic [DW-1:0]    word;
  logic [DW-1:0]    left_hold;
  logic             have_left;

  assign raw_v = {sclk_in, ws_in, sd_in};

  sarx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_v), .q(syn_v)
  );
  assign {sclk_s, ws_s, sd_s} = syn_v;

  sarx_framer #(.CNT_W(CNT_W)) u_framer (
    .clk(clk), .rst(rst), .sclk_s(sclk_s), .ws_s(ws_s),
    .bit_stb(bit_stb), .ws_chg(ws_chg), .ws_last(ws_last),
    .locked(locked), .pos(pos)
  );

  sarx_capture #(.DW(DW), .CNT_W(CNT_W)) u_capture (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_sd(sd_s),
    .ws_chg(ws_chg), .locked(locked), .pos(pos), .fmt(fmt_act),
    .word_stb(word_stb), .word(word)
  );

  // Format is adopted only where a left half-frame begins
  always_ff @(posedge clk) begin
    if (rst) fmt_act <= FMT_I2S24;
    else if (ws_chg && (ws_s == left_level(fmt_in))) fmt_act <= fmt_in;
  end

  assign is_left = (ws_last == left_level(fmt_act));

  always_ff @(posedge clk) begin
    if (rst) begin
      left_hold <= '0;
      have_left <= 1'b0;
      left_out  <= '0;
      right_out <= '0;
      valid_out <= 1'b0;
    end else begin
      valid_out <= 1'b0;
      if (word_stb) begin
        if (is_left) begin
          left_hold <= word;
          have_left <= 1'b1;
        end else if (have_left) begin
          left_out  <= left_hold;
          right_out <= word;
          valid_out <= 1'b1;
          have_left <= 1'b0;
        end
      end
    end
  end

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_out |=> !valid_out);

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_out |-> ($stable(left_out) && $stable(right_out)));

  // R6
  fmt_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(fmt_act) |-> $past(ws_chg));
endmodule

// File: tb/serial_audio_rx_bench.sv
module serial_audio_rx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk_in = 1'b0;
  logic        ws_in = 1'b0;
  logic        sd_in = 1'b0;
  logic [2:0]  fmt_in = 3'b000;
  logic [23:0] left_out, right_out;
  logic        valid_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit mon_en = 1'b0;
  int nexp   = 0;
  int got    = 0;
  string cur_tag = "";
  logic [23:0] exp_l [0:15];
  logic [23:0] exp_r [0:15];
  logic [23:0] raw_l [0:15];
  logic [23:0] raw_r [0:15];
  logic carry = 1'b1;

  always #10 clk = ~clk;

  serial_audio_rx u_serial_audio_rx (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .ws_in(ws_in), .sd_in(sd_in),
    .fmt_in(fmt_in), .left_out(left_out), .right_out(right_out),
    .valid_out(valid_out)
  );

  task automatic chk(input bit ok, input string what, input logic [23:0] act,
                     input logic [23:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, expv);
    end
  endtask

  function automatic int width_of(input logic [2:0] f);
    case (f)
      3'b000: return 16;
      3'b001: return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic [23:0] mask_of(input int w);
    return (24'h1 << w) - 24'h1;
  endfunction

  function automatic logic [23:0] sx(input logic [23:0] v, input int w);
    logic [23:0] m = mask_of(w);
    return v[w-1] ? (v | ~m) : (v & m);
  endfunction

  function automatic logic [23:0] gen(input int k, input int salt, input int w);
    logic [23:0] m = mask_of(w);
    logic [31:0] h;
    case (k)
      0: return 24'h0;
      1: return m >> 1;
      2: return (m >> 1) + 24'h1;
      3: return m;
      default: begin
        h = 32'(k) * 32'h9E3779B1 + 32'(salt) * 32'h7F4A7C15;
        return h[28:5] & m;
      end
    endcase
  endfunction

  // Output monitor: compares each presented pair in arrival order
  always @(negedge clk) begin
    if (mon_en && valid_out) begin
      if (got < nexp) begin
        chk(left_out == exp_l[got], {cur_tag, " R5 left"}, left_out, exp_l[got]);
        chk(right_out == exp_r[got], {cur_tag, " R5 right"}, right_out, exp_r[got]);
      end
      got++;
    end
  end

  task automatic send_bit(input logic w, input logic d);
    @(negedge clk);
    ws_in = w;
    sd_in = d;
    repeat (3) @(negedge clk);
    sclk_in = 1'b1;
    repeat (4) @(negedge clk);
    sclk_in = 1'b0;
  endtask

  task automatic send_frame(input logic [2:0] f, input int hl, input logic [23:0] lw,
                            input logic [23:0] rw, input int sw_slot,
                            input logic [2:0] sw_fmt);
    int w = width_of(f);
    for (int s = 0; s < 2 * hl; s++) begin
      bit half = (s >= hl);
      int p = half ? s - hl : s;
      logic [23:0] wd = half ? rw : lw;
      logic wsb = (f == 3'b011) ? half : !half;
      logic b = 1'b1;
      int k;
      if (s == sw_slot) fmt_in = sw_fmt;
      case (f)
        3'b000, 3'b001, 3'b100: begin
          k = p - (hl - w);
          if (k >= 0) b = wd[w-1-k];
        end
        3'b011: begin
          if (p == 0) b = carry;
          else if (p <= 24) b = wd[24-p];
        end
        default: if (p < 24) b = wd[23-p];
      endcase
      if (f == 3'b011 && p == hl - 1) carry = (hl == 24) ? wd[0] : 1'b1;
      send_bit(wsb, b);
    end
  endtask

  task automatic start_stream(input logic [2:0] f);
    logic idle_ws = (f == 3'b011) ? 1'b1 : 1'b0;
    rst = 1'b1;
    fmt_in = f;
    sclk_in = 1'b0;
    ws_in = idle_ws;
    sd_in = 1'b0;
    carry = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    got = 0;
    mon_en = 1'b1;
    for (int i = 0; i < 4; i++) send_bit(idle_ws, 1'b1);
  endtask

  task automatic run_cfg(input logic [2:0] f, input int hl, input int nfr,
                         input int salt, input string tag);
    int w = width_of(f);
    cur_tag = tag;
    for (int k = 0; k < nfr; k++) begin
      raw_l[k] = gen(k, salt, w);
      raw_r[k] = gen(k + 5, salt + 1, w);
      exp_l[k] = sx(raw_l[k], w);
      exp_r[k] = sx(raw_r[k], w);
    end
    exp_l[nfr] = '0;
    exp_r[nfr] = '0;
    nexp = nfr + 1;
    start_stream(f);
    for (int k = 0; k < nfr; k++) send_frame(f, hl, raw_l[k], raw_r[k], -1, f);
    send_frame(f, hl, 24'h0, 24'h0, -1, f);
    repeat (20) @(negedge clk);
    mon_en = 1'b0;
    chk(got >= nfr, {tag, " pair count"}, 24'(got), 24'(nfr));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R8: reset state
    rst = 1'b0;
    @(negedge clk);
    chk(left_out == 24'h0, "R8 left after reset", left_out, 24'h0);
    chk(right_out == 24'h0, "R8 right after reset", right_out, 24'h0);
    chk(valid_out == 1'b0, "R8 valid after reset", 24'(valid_out), 24'h0);

    // R1 R2 R3 R4 R9: every format at minimum and at 32-slot half-frames
    run_cfg(3'b000, 16, 6, 11, "R1 R4 min");
    run_cfg(3'b000, 32, 6, 12, "R1 R4 R9");
    run_cfg(3'b001, 20, 6, 13, "R1 R4 min");
    run_cfg(3'b001, 32, 6, 14, "R1 R4 R9");
    run_cfg(3'b100, 24, 6, 15, "R1 min");
    run_cfg(3'b100, 32, 6, 16, "R1 R9");
    run_cfg(3'b010, 24, 6, 17, "R2 min");
    run_cfg(3'b010, 32, 6, 18, "R2 R9");
    run_cfg(3'b011, 24, 6, 19, "R3 min");
    run_cfg(3'b011, 32, 6, 20, "R3 R9");

    // R6: switch code 010 -> 100 in the middle of frame 1
    cur_tag = "R6";
    for (int k = 0; k < 4; k++) begin
      raw_l[k] = gen(k + 1, 30, 24);
      raw_r[k] = gen(k + 6, 31, 24);
      exp_l[k] = raw_l[k];
      exp_r[k] = raw_r[k];
    end
    exp_l[4] = '0;
    exp_r[4] = '0;
    nexp = 5;
    start_stream(3'b010);
    send_frame(3'b010, 32, raw_l[0], raw_r[0], -1, 3'b010);
    send_frame(3'b010, 32, raw_l[1], raw_r[1], 5, 3'b100);
    send_frame(3'b100, 32, raw_l[2], raw_r[2], -1, 3'b100);
    send_frame(3'b100, 32, raw_l[3], raw_r[3], -1, 3'b100);
    send_frame(3'b100, 32, 24'h0, 24'h0, -1, 3'b100);
    repeat (20) @(negedge clk);
    mon_en = 1'b0;
    chk(got >= 4, "R6 pair count", 24'(got), 24'd4);

    // R7: unsupported code yields no pairs
    cur_tag = "R7";
    nexp = 0;
    start_stream(3'b101);
    for (int k = 0; k < 3; k++) send_frame(3'b101, 32, 24'h5A5A5A, 24'hA5A5A5, -1, 3'b101);
    repeat (20) @(negedge clk);
    mon_en = 1'b0;
    chk(got == 0, "R7 no valid on code 101", 24'(got), 24'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule